// File: doc/BRIEF.md
# Two-Wire Serial Register Write Slave

This block is the slave end of a two-wire serial control port that only accepts writes. The bus has a clock line and a shared open-drain data line. A bus master opens a transfer with a start condition. It then sends three bytes, most significant bit first. The first byte carries a 7-bit device address and a direction bit. The second carries a register address. The third carries the register value. When the device address matches and the direction is write, the block pulls the data line low in the ninth clock of each byte as an acknowledge. After the third acknowledge it hands the register address and value to an internal register file with a one-cycle write strobe.

Both bus lines pass through two-flop synchronisers into the system clock. All bus events are found on the synchronised copies. The block never drives the data line high: it only asserts an output enable that pulls the line low. Every transaction is exactly one register write. A start or stop condition in the middle of a transaction discards it and sends the block back to idle without a strobe.

Top module: `twi_wr_slave`

## Requirements
- R1: After reset the acknowledge enable `sda_oe_o` is low, `wr_en_o` is low, and `wr_addr_o` and `wr_data_o` are zero.
- R2: A start condition is a fall of the data line while the clock line is high. From idle it begins reception of the first byte. Bits are sampled on clock rising edges, most significant bit first.
- R3: If the first byte holds bits [7:1] equal to parameter `DEV_ADDR` and bit 0 equal to 0 (write), the block pulls the data line low. The pull starts after the falling clock edge that ends the eighth bit and is released after the falling edge that ends the ninth clock.
- R4: If the device address in bits [7:1] does not match, the block returns to idle without acknowledging. The rest of that transfer gets no acknowledge and causes no strobe.
- R5: A matching address with bit 0 equal to 1 (read) is not acknowledged and causes no strobe.
- R6: The second byte is acknowledged. Only its bits [6:0] form the register address; bit 7 is ignored.
- R7: The third byte is acknowledged. After the falling edge that ends its ninth clock, `wr_en_o` pulses high for exactly one system clock. In that cycle `wr_addr_o` and `wr_data_o` carry the received register address and data, and they change only in a strobe cycle.
- R8: A start condition during a transfer aborts it to idle. The bytes that follow are not acknowledged and no strobe is issued.
- R9: A stop condition (a rise of the data line while the clock line is high) during a transfer aborts it to idle with no strobe. A stop from idle has no effect.
- R10: Transfers sent one after another each produce exactly one strobe with their own address and data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe_o | output | 1 | When high, pulls the data line low |
| wr_en_o | output | 1 | One-cycle register write strobe |
| wr_addr_o | output | 7 | Register address for the write |
| wr_data_o | output | 8 | Register data for the write |

## Verification
The bench checks the acknowledge window on both sides. The data line must already be low before the ninth clock rises, and it must be free again after that clock falls. A design that acknowledged one clock late, or held the line too long, would corrupt the master's next bit. Transfers with a wrong address, a read direction bit, or a start or stop inserted mid-transfer must end with no strobe and no later acknowledges. A design that failed to return to idle would still write the register file. The bench also sends a register byte with its top bit set, which catches a design that keeps eight bits. It sends two transfers back to back, which catches state left over from the first.

// File: rtl/twi_pkg.sv
package twi_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEV,
    ST_DEV_ACK,
    ST_REG,
    ST_REG_ACK,
    ST_DAT,
    ST_DAT_ACK
  } twi_state_e;
endpackage

// File: rtl/twi_sync.sv
module twi_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[s] <= '1;  // idle bus reads high
      else if (s == 0) stage_q[s] <= d_i;
      else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/twi_cond.sv
module twi_cond (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_s_i,
  input  logic sda_s_i,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s_i;
      sda_q <= sda_s_i;
    end
  end

  assign scl_rise_o = scl_s_i & ~scl_q;
  assign scl_fall_o = ~scl_s_i & scl_q;
  // data edge while clock held high on both samples
  assign start_o    = scl_s_i & scl_q & sda_q & ~sda_s_i;
  assign stop_o     = scl_s_i & scl_q & ~sda_q & sda_s_i;
endmodule

// File: rtl/twi_fsm.sv
module twi_fsm
  import twi_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h3A,
  parameter int         REG_AW   = 7,
  parameter int         DW       = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sda_s_i,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              start_i,
  input  logic              stop_i,
  output twi_state_e        state_o,
  output logic              sda_oe_o,
  output logic              wr_en_o,
  output logic [REG_AW-1:0] wr_addr_o,
  output logic [DW-1:0]     wr_data_o
);
  localparam int CNT_W = $clog2(DW + 1);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DW);

  twi_state_e        state_q;
  logic [DW-1:0]     shift_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [REG_AW-1:0] reg_q;
  logic [DW-1:0]     dat_q;
  logic              byte_done;

  assign byte_done = scl_fall_i && (cnt_q == LAST_BIT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      shift_q   <= '0;
      cnt_q     <= '0;
      reg_q     <= '0;
      dat_q     <= '0;
      wr_en_o   <= 1'b0;
      wr_addr_o <= '0;
      wr_data_o <= '0;
    end else begin
      wr_en_o <= 1'b0;
      if (start_i) begin
        cnt_q   <= '0;
        state_q <= (state_q == ST_IDLE) ? ST_DEV : ST_IDLE;
      end else if (stop_i) begin
        cnt_q   <= '0;
        state_q <= ST_IDLE;
      end else begin
        unique case (state_q)
          ST_DEV, ST_REG, ST_DAT: begin
            if (scl_rise_i) begin
              shift_q <= {shift_q[DW-2:0], sda_s_i};
              cnt_q   <= cnt_q + 1'b1;
            end
            if (byte_done) begin
              cnt_q <= '0;
              if (state_q == ST_DEV)
                state_q <= (shift_q[DW-1:1] == DEV_ADDR && !shift_q[0]) ? ST_DEV_ACK : ST_IDLE;
              else if (state_q == ST_REG) begin
                reg_q   <= shift_q[REG_AW-1:0];
                state_q <= ST_REG_ACK;
              end else begin
                dat_q   <= shift_q;
                state_q <= ST_DAT_ACK;
              end
            end
          end
          ST_DEV_ACK: if (scl_fall_i) state_q <= ST_REG;
          ST_REG_ACK: if (scl_fall_i) state_q <= ST_DAT;
          ST_DAT_ACK: if (scl_fall_i) begin
            wr_en_o   <= 1'b1;
            wr_addr_o <= reg_q;
            wr_data_o <= dat_q;
            state_q   <= ST_IDLE;
          end
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end

  assign state_o  = state_q;
  assign sda_oe_o = (state_q == ST_DEV_ACK) || (state_q == ST_REG_ACK) ||
                    (state_q == ST_DAT_ACK);
endmodule

// File: rtl/twi_wr_slave.sv
module twi_wr_slave
  import twi_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'h3A,
  parameter int         SYNC_STAGES = 2,
  parameter int         REG_AW      = 7,
  parameter int         DW          = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe_o,
  output logic              wr_en_o,
  output logic [REG_AW-1:0] wr_addr_o,
  output logic [DW-1:0]     wr_data_o
);
  logic [1:0] line_s;
  logic       scl_s, sda_s;
  logic       scl_rise, scl_fall, start_det, stop_det;
  twi_state_e state;

  twi_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .d_i({scl_i, sda_i}), .q_o(line_s)
  );
  assign scl_s = line_s[1];
  assign sda_s = line_s[0];

  twi_cond u_cond (
    .clk_i, .rst_ni, .scl_s_i(scl_s), .sda_s_i(sda_s),
    .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start_det), .stop_o(stop_det)
  );

  twi_fsm #(.DEV_ADDR(DEV_ADDR), .REG_AW(REG_AW), .DW(DW)) u_fsm (
    .clk_i, .rst_ni, .sda_s_i(sda_s),
    .scl_rise_i(scl_rise), .scl_fall_i(scl_fall),
    .start_i(start_det), .stop_i(stop_det),
    .state_o(state), .sda_oe_o, .wr_en_o, .wr_addr_o, .wr_data_o
  );
endmodule

// File: rtl/twi_wr_slave_chk.sv
module twi_wr_slave_chk
  import twi_pkg::*;
#(
  parameter int REG_AW = 7,
  parameter int DW     = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              scl_s,
  input logic              scl_fall,
  input logic              stop_det,
  input twi_state_e        state,
  input logic              sda_oe_o,
  input logic              wr_en_o,
  input logic [REG_AW-1:0] wr_addr_o,
  input logic [DW-1:0]     wr_data_o
);
  p_strobe_single_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |=> !wr_en_o);

  p_strobe_after_ack_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wr_en_o) |-> $past(sda_oe_o));

  p_outputs_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !($stable(wr_addr_o) && $stable(wr_data_o)) |-> wr_en_o);

  p_ack_on_fall_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sda_oe_o) |-> $past(scl_fall));

  p_ack_clk_low_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sda_oe_o) |-> !scl_s);

  p_stop_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_det |=> (state == ST_IDLE && !wr_en_o));
endmodule

bind twi_wr_slave twi_wr_slave_chk #(.REG_AW(REG_AW), .DW(DW)) chk_i (
  .clk_i, .rst_ni, .scl_s, .scl_fall, .stop_det, .state,
  .sda_oe_o, .wr_en_o, .wr_addr_o, .wr_data_o
);

// File: tb/twi_wr_slave_tb_top.sv
`timescale 1ns/1ps
module twi_wr_slave_tb_top;
  localparam logic [6:0] DEV = 7'h3A;

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl = 1'b1, msda = 1'b1;
  logic sda_oe, wr_en;
  logic [6:0] wr_addr;
  logic [7:0] wr_data;
  wire  sda_line = msda & ~sda_oe;

  int checks = 0, fails = 0;
  int strobes = 0, wide = 0;
  logic [6:0] last_addr;
  logic [7:0] last_data;
  logic ack_pre, ack_mid, oe_post;

  always #5 clk = ~clk;

  twi_wr_slave #(.DEV_ADDR(DEV)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl), .sda_i(sda_line),
    .sda_oe_o(sda_oe), .wr_en_o(wr_en), .wr_addr_o(wr_addr), .wr_data_o(wr_data)
  );

  logic en_prev = 1'b0;
  always @(negedge clk) begin
    if (wr_en) begin
      strobes++;
      last_addr = wr_addr;
      last_data = wr_data;
      if (en_prev) wide++;
    end
    en_prev = wr_en;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    msda = 1'b1; wt(10); scl = 1'b1; wt(20);
    msda = 1'b0; wt(20); scl = 1'b0; wt(10);
  endtask

  task automatic bus_stop();
    msda = 1'b0; wt(10); scl = 1'b1; wt(20);
    msda = 1'b1; wt(20);
  endtask

  task automatic send_bit(input logic b);
    msda = b; wt(10); scl = 1'b1; wt(20); scl = 1'b0; wt(10);
  endtask

  // sends 8 bits then runs the ninth clock, recording the line around it
  task automatic send_byte(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    msda = 1'b1; wt(10);
    ack_pre = ~sda_line;
    scl = 1'b1; wt(10);
    ack_mid = ~sda_line;
    wt(10); scl = 1'b0; wt(10);
    oe_post = sda_oe;
  endtask

  task automatic t_reset();
    chk(sda_oe == 0, "R1", "oe", sda_oe, 0);
    chk(wr_en == 0, "R1", "strobe", wr_en, 0);
    chk(wr_addr == 0 && wr_data == 0, "R1", "addr/data", {wr_addr, wr_data}, 0);
  endtask

  task automatic t_write(input logic [7:0] rbyte, input logic [7:0] dbyte, input string req);
    int s0 = strobes;
    bus_start();
    send_byte({DEV, 1'b0});
    chk(ack_pre && ack_mid, "R3", "dev ack low", {ack_pre, ack_mid}, 3);
    chk(!oe_post, "R3", "dev ack released", oe_post, 0);
    send_byte(rbyte);
    chk(ack_mid && !oe_post, "R6", "reg ack", {ack_mid, oe_post}, 2);
    chk(strobes == s0, "R7", "no early strobe", strobes - s0, 0);
    send_byte(dbyte);
    chk(ack_mid && !oe_post, "R7", "data ack", {ack_mid, oe_post}, 2);
    chk(strobes == s0 + 1, req, "strobe count", strobes - s0, 1);
    chk(last_addr == rbyte[6:0], "R6", "reg addr", last_addr, rbyte[6:0]);
    chk(last_data == dbyte, req, "data", last_data, dbyte);
    bus_stop();
    chk(wr_addr == rbyte[6:0] && wr_data == dbyte, "R7", "outputs held",
        {wr_addr, wr_data}, {rbyte[6:0], dbyte});
  endtask

  task automatic t_no_ack(input logic [7:0] first, input string req);
    int s0 = strobes;
    bus_start();
    send_byte(first);
    chk(!ack_pre && !ack_mid, req, "no first ack", {ack_pre, ack_mid}, 0);
    send_byte(8'h11);
    chk(!ack_mid, req, "no reg ack", ack_mid, 0);
    send_byte(8'h22);
    chk(!ack_mid, req, "no data ack", ack_mid, 0);
    bus_stop();
    chk(strobes == s0, req, "no strobe", strobes - s0, 0);
  endtask

  task automatic t_mid_start();
    int s0 = strobes;
    bus_start();
    send_byte({DEV, 1'b0});
    chk(ack_mid, "R8", "dev ack", ack_mid, 1);
    send_bit(1'b0); send_bit(1'b1);
    msda = 1'b1; wt(10); scl = 1'b1; wt(20); msda = 1'b0; wt(20); scl = 1'b0; wt(10);
    send_byte(8'h07);
    chk(!ack_mid, "R8", "no ack after restart", ack_mid, 0);
    send_byte(8'h99);
    chk(!ack_mid, "R8", "no data ack", ack_mid, 0);
    bus_stop();
    chk(strobes == s0, "R8", "no strobe", strobes - s0, 0);
  endtask

  task automatic t_mid_stop();
    int s0 = strobes;
    bus_stop();
    chk(strobes == s0 && !sda_oe, "R9", "idle stop", strobes - s0, 0);
    bus_start();
    send_byte({DEV, 1'b0});
    send_byte(8'h0C);
    chk(ack_mid, "R9", "reg ack", ack_mid, 1);
    bus_stop();
    scl = 1'b0; wt(10);
    send_byte(8'hA5);
    chk(!ack_mid, "R9", "no data ack after stop", ack_mid, 0);
    scl = 1'b1; wt(20);
    chk(strobes == s0, "R9", "no strobe", strobes - s0, 0);
  endtask

  initial begin
    wt(5);
    t_reset();
    rst_n = 1'b1; wt(5);
    t_reset();
    t_write(8'h85, 8'hC3, "R2");
    t_no_ack({DEV ^ 7'h01, 1'b0}, "R4");
    t_no_ack({DEV, 1'b1}, "R5");
    t_mid_start();
    t_mid_stop();
    t_write(8'h12, 8'h5A, "R10");
    t_write(8'h7F, 8'h00, "R10");
    chk(wide == 0, "R7", "strobe width", wide, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule